// File: doc/BRIEF.md
# Byte-Banked Word Access Sequencer

This block connects a requester to a 16-bit memory made of two byte-wide banks. One bank holds the even byte addresses and the other holds the odd ones. The requester asks for a byte or word read or write at a 20-bit byte address. The sequencer turns each request into one or two bus cycles. In each bus cycle it drives a 19-bit bank address, an active-low odd-bank select (`bhe_n`) and the even-bank select (`a0`, active low). It also steers bytes between the requester's 16-bit data and the two byte lanes.

A word that starts at an odd address does not fit in one bank row. The block splits it into two bus cycles. The first cycle uses the odd bank at the starting row. The second cycle uses the even bank at the next row. The two bytes are swapped between lanes so that the requester always sees a plain little-endian word. Both bank arrays are part of the block. Each array holds `2**BANK_DEPTH_LOG2` bytes and is indexed by the low bits of the bank address.

The requester side uses a valid/ready handshake. A one-cycle `done` pulse ends every request, and for reads it carries the assembled data.

Top module: `lane_split_mem`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `req_ready`=1, `bhe_n`=1, `a0`=1, `bus_we`=0, `done`=0, `rdata`=0 and `bus_addr`=0.
- R2: A word access at an even address A takes one bus cycle, in the cycle after acceptance, with `bhe_n`=0, `a0`=0 and `bus_addr`=A[19:1]. `done` rises in the cycle after that. A read returns byte A in `rdata[7:0]` and byte A+1 in `rdata[15:8]`.
- R3: A byte access at an even address takes one bus cycle with `bhe_n`=1, `a0`=0 and `bus_addr`=A[19:1]. A read returns the byte in `rdata[7:0]` with `rdata[15:8]`=0.
- R4: A byte access at an odd address takes one bus cycle with `bhe_n`=0, `a0`=1 and `bus_addr`=A[19:1]. The byte travels on the odd lane but is returned in `rdata[7:0]` with `rdata[15:8]`=0.
- R5: A word access at an odd address N takes two back-to-back bus cycles. The first has `bhe_n`=0, `a0`=1 and `bus_addr`=N[19:1]. The second has `bhe_n`=1, `a0`=0 and `bus_addr`=N[19:1]+1. `done` follows in the next cycle. A read returns byte N in bits 7..0 and byte N+1 in bits 15..8. A write stores `req_wdata[7:0]` at N and `req_wdata[15:8]` at N+1.
- R6: For a split word at N = FFFFFh, the second bus cycle uses `bus_addr`=0, so byte N+1 wraps to byte address 00000h.
- R7: A byte write changes only the addressed byte. The other byte of the same bank row keeps its value.
- R8: `req_ready` is high only when the block is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` is ignored at every other edge, including the `done` cycle. `done` is high for exactly one cycle per request.
- R9: `rdata` is zero in every cycle except the `done` cycle of a read.
- R10: `bus_we` is high exactly in the bus cycles of a write request.
- R11: Outside bus cycles, including the `done` cycle, `bhe_n`=1, `a0`=1, `bus_we`=0 and `bus_addr`=0.
- R12: Each bank stores a byte at index `bus_addr[BANK_DEPTH_LOG2-1:0]`. Byte addresses that agree in bits `BANK_DEPTH_LOG2..0` share one storage byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits 7..0 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with `done` on reads |
| bus_addr | output | 19 | Bank row address |
| bhe_n | output | 1 | Odd-bank select, active low |
| a0 | output | 1 | Even-bank select, active low |
| bus_we | output | 1 | Write strobe for the selected banks |

## Verification
The `done` cycle of one request can coincide with the next request already waiting on `req_valid`. It can also coincide with a stray request raised while a transfer is still in flight. The bench provokes both cases in two ways. It issues requests back to back with valid held high through completion. It also raises a different request during a busy transfer and drops it before the block returns to idle. A behavioural model predicts, for every clock, whether the block is idle, what each bus cycle looks like and what the assembled word is. The check is that acceptance happens only in an idle cycle and never in the `done` cycle, and that the ignored request leaves no trace on the bus or in memory.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int BYTE_AW = 20;
    localparam int ROW_AW  = BYTE_AW - 1;
    localparam int DATA_W  = 16;
    localparam int LANE_W  = DATA_W / 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_FIN    = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic                write;
        logic                word;
        logic [BYTE_AW-1:0]  addr;
        logic [DATA_W-1:0]   wdata;
    } req_t;

    // bhe_n selects the odd bank, a0 low selects the even bank
    typedef struct packed {
        logic bhe_n;
        logic a0;
    } bank_sel_t;

    localparam bank_sel_t SEL_NONE = bank_sel_t'(2'b11);
    localparam bank_sel_t SEL_BOTH = bank_sel_t'(2'b00);
    localparam bank_sel_t SEL_EVEN = bank_sel_t'(2'b10);
    localparam bank_sel_t SEL_ODD  = bank_sel_t'(2'b01);

    // select pattern of the first (or only) bus cycle of a request
    function automatic bank_sel_t first_sel(input logic word, input logic odd);
        if (odd)
            return SEL_ODD;
        else if (word)
            return SEL_BOTH;
        else
            return SEL_EVEN;
    endfunction

    function automatic logic even_on(input bank_sel_t s);
        return !s.a0;
    endfunction

    function automatic logic odd_on(input bank_sel_t s);
        return !s.bhe_n;
    endfunction

endpackage

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
    import lsm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  req_t                 req_in,
    output logic                 req_ready,
    output req_t                 cur,
    output logic                 in_second,
    output logic                 in_fin,
    output logic [ROW_AW-1:0]    bus_addr,
    output bank_sel_t            sel,
    output logic                 bus_we
);

    seq_state_t           state;
    logic [ROW_AW-1:0]    row_first;
    logic [ROW_AW-1:0]    row_next;
    logic                 split;

    assign row_first = cur.addr[BYTE_AW-1:1];
    assign row_next  = row_first + ROW_AW'(1);
    assign split     = cur.word && cur.addr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur   <= req_in;
                        state <= ST_FIRST;
                    end
                end
                ST_FIRST:  state <= split ? ST_SECOND : ST_FIN;
                ST_SECOND: state <= ST_FIN;
                ST_FIN:    state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_addr = '0;
        sel      = SEL_NONE;
        bus_we   = 1'b0;
        case (state)
            ST_FIRST: begin
                bus_addr = row_first;
                sel      = first_sel(cur.word, cur.addr[0]);
                bus_we   = cur.write;
            end
            ST_SECOND: begin
                bus_addr = row_next;
                sel      = SEL_EVEN;
                bus_we   = cur.write;
            end
            default: ;
        endcase
    end

    assign req_ready = (state == ST_IDLE);
    assign in_second = (state == ST_SECOND);
    assign in_fin    = (state == ST_FIN);

endmodule

// File: rtl/lsm_lanes.sv
module lsm_lanes
    import lsm_pkg::*;
(
    input  logic                cur_write,
    input  logic                cur_word,
    input  logic                cur_odd,
    input  logic [DATA_W-1:0]   cur_wdata,
    input  logic                in_second,
    input  logic                in_fin,
    input  logic [LANE_W-1:0]   even_q,
    input  logic [LANE_W-1:0]   odd_q,
    output logic [LANE_W-1:0]   even_wd,
    output logic [LANE_W-1:0]   odd_wd,
    output logic [DATA_W-1:0]   rdata
);

    logic [LANE_W-1:0] w_lo;
    logic [LANE_W-1:0] w_hi;

    assign w_lo = cur_wdata[LANE_W-1:0];
    assign w_hi = cur_wdata[DATA_W-1:LANE_W];

    // odd lane takes the high byte only for an aligned word
    assign odd_wd  = (cur_word && !cur_odd) ? w_hi : w_lo;
    // even lane takes the high byte only in the second half of a split word
    assign even_wd = in_second ? w_hi : w_lo;

    always_comb begin
        rdata = '0;
        if (in_fin && !cur_write) begin
            if (cur_word)
                rdata = cur_odd ? {even_q, odd_q} : {odd_q, even_q};
            else
                rdata = {{LANE_W{1'b0}}, (cur_odd ? odd_q : even_q)};
        end
    end

endmodule

// File: rtl/lsm_bank.sv
module lsm_bank
    import lsm_pkg::*;
#(
    parameter int DEPTH_LOG2 = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs,
    input  logic                   we,
    input  logic [DEPTH_LOG2-1:0]  idx,
    input  logic [LANE_W-1:0]      wd,
    output logic [LANE_W-1:0]      q
);

    localparam int DEPTH = 1 << DEPTH_LOG2;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (cs && we)
            mem[idx] <= wd;
    end

    // read register holds its value while the bank is not selected
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (cs && !we)
            q <= mem[idx];
    end

endmodule

// File: rtl/lane_split_mem.sv
module lane_split_mem
    import lsm_pkg::*;
#(
    parameter int BANK_DEPTH_LOG2 = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_word,
    input  logic [19:0]          req_addr,
    input  logic [15:0]          req_wdata,
    output logic                 done,
    output logic [15:0]          rdata,
    output logic [18:0]          bus_addr,
    output logic                 bhe_n,
    output logic                 a0,
    output logic                 bus_we
);

    localparam int NUM_BANKS = 2;

    req_t                req_in;
    req_t                cur;
    bank_sel_t           sel;
    logic                in_second;
    logic                in_fin;
    logic [NUM_BANKS-1:0] lane_cs;
    logic [LANE_W-1:0]   lane_wd [NUM_BANKS];
    logic [LANE_W-1:0]   lane_q  [NUM_BANKS];

    assign req_in = '{write: req_write, word: req_word, addr: req_addr, wdata: req_wdata};

    lsm_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .req_ready (req_ready),
        .cur       (cur),
        .in_second (in_second),
        .in_fin    (in_fin),
        .bus_addr  (bus_addr),
        .sel       (sel),
        .bus_we    (bus_we)
    );

    lsm_lanes u_lanes (
        .cur_write (cur.write),
        .cur_word  (cur.word),
        .cur_odd   (cur.addr[0]),
        .cur_wdata (cur.wdata),
        .in_second (in_second),
        .in_fin    (in_fin),
        .even_q    (lane_q[0]),
        .odd_q     (lane_q[1]),
        .even_wd   (lane_wd[0]),
        .odd_wd    (lane_wd[1]),
        .rdata     (rdata)
    );

    assign lane_cs[0] = even_on(sel);
    assign lane_cs[1] = odd_on(sel);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        lsm_bank #(.DEPTH_LOG2(BANK_DEPTH_LOG2)) u_bank (
            .clk (clk),
            .rst (rst),
            .cs  (lane_cs[g]),
            .we  (bus_we),
            .idx (bus_addr[BANK_DEPTH_LOG2-1:0]),
            .wd  (lane_wd[g]),
            .q   (lane_q[g])
        );
    end

    assign done  = in_fin;
    assign bhe_n = sel.bhe_n;
    assign a0    = sel.a0;

endmodule

// File: rtl/lane_split_mem_chk.sv
module lane_split_mem_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        done,
    input logic        bhe_n,
    input logic        a0,
    input logic        bus_we,
    input logic [18:0] bus_addr,
    input logic        in_second
);

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (bhe_n && a0 && !bus_we)) else $error("idle select"); // R11

    AST_DONE_DESELECT: assert property (@(posedge clk) disable iff (rst)
        done |-> (bhe_n && a0 && !bus_we && bus_addr == 19'd0)) else $error("done select"); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done width"); // R8

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready) else $error("accept"); // R8

    AST_BUS_SELECTED: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !done) |-> !(bhe_n && a0)) else $error("bus cycle select"); // R2

    AST_SPLIT_SECOND: assert property (@(posedge clk) disable iff (rst)
        in_second |-> (bhe_n && !a0 && $past(!bhe_n && a0)
                       && bus_addr == $past(bus_addr) + 19'd1)) else $error("split"); // R5 R6

endmodule

bind lane_split_mem lane_split_mem_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .bhe_n     (bhe_n),
    .a0        (a0),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .in_second (in_second)
);

// File: tb/lane_split_mem_bench.sv
module lane_split_mem_bench;

    localparam int DL = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word  = 1'b0;
    logic [19:0] req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done, bhe_n, a0, bus_we;
    logic [18:0] bus_addr;
    logic [15:0] rdata;

    always #5 clk = ~clk;

    lane_split_mem #(.BANK_DEPTH_LOG2(DL)) u_lane_split_mem (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rdata(rdata), .bus_addr(bus_addr),
        .bhe_n(bhe_n), .a0(a0), .bus_we(bus_we)
    );

    typedef struct {
        logic        bhe_n;
        logic        a0;
        logic        we;
        logic        done;
        logic [18:0] addr;
        logic [15:0] rd;
        string       tag;
    } exp_t;

    exp_t       q[$];
    logic [7:0] mem_m [0:(1<<(DL+1))-1];
    logic       cur_idle = 1'b0;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;

    function automatic int eff(input logic [19:0] a);
        return int'({a[DL:1], a[0]});
    endfunction

    task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", r, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // behavioural model: plan the bus cycles of a request at acceptance
    always @(posedge clk) begin
        if (!rst && cur_idle && req_valid) begin
            logic [19:0] n, nx;
            logic [15:0] rd;
            string       t;
            n  = req_addr;
            nx = n + 20'd1;
            rd = '0;
            if (req_word && n[0])      t = (n == 20'hFFFFF) ? "R6" : "R5";
            else if (req_word)         t = "R2";
            else if (req_write)        t = "R7";
            else                       t = n[0] ? "R4" : "R3";
            if (req_write) begin
                mem_m[eff(n)] = req_wdata[7:0];
                if (req_word) mem_m[eff(nx)] = req_wdata[15:8];
            end else if (req_word) begin
                rd = {mem_m[eff(nx)], mem_m[eff(n)]};
            end else begin
                rd = {8'h00, mem_m[eff(n)]};
            end
            if (req_word && n[0]) begin
                q.push_back('{1'b0, 1'b1, req_write, 1'b0, n[19:1], 16'h0, t});
                q.push_back('{1'b1, 1'b0, req_write, 1'b0, nx[19:1], 16'h0, t});
            end else if (req_word) begin
                q.push_back('{1'b0, 1'b0, req_write, 1'b0, n[19:1], 16'h0, t});
            end else begin
                q.push_back('{!n[0], n[0], req_write, 1'b0, n[19:1], 16'h0, t});
            end
            q.push_back('{1'b1, 1'b1, 1'b0, 1'b1, 19'h0, rd, req_write ? "R9" : t});
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() == 0) begin
                cur_idle = 1'b1;
                chk("R8",  "ready",  req_ready, 1);
                chk("R11", "bhe_n",  bhe_n, 1);
                chk("R11", "a0",     a0, 1);
                chk("R10", "we",     bus_we, 0);
                chk("R11", "addr",   bus_addr, 0);
                chk("R8",  "done",   done, 0);
                chk("R9",  "rdata",  rdata, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                cur_idle = 1'b0;
                chk("R8",  "ready",  req_ready, 0);
                chk(e.tag, "bhe_n",  bhe_n, e.bhe_n);
                chk(e.tag, "a0",     a0, e.a0);
                chk("R10", "we",     bus_we, e.we);
                chk(e.tag, "addr",   bus_addr, e.addr);
                chk("R8",  "done",   done, e.done);
                chk(e.tag, "rdata",  rdata, e.rd);
            end
        end
    end

    task automatic issue(input logic w, input logic wd, input logic [19:0] a, input logic [15:0] d);
        req_valid = 1'b1; req_write = w; req_word = wd; req_addr = a; req_wdata = d;
        forever begin
            @(posedge clk);
            if (cur_idle) break;
        end
        #1 req_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "ready", req_ready, 1);
        chk("R1", "bhe_n", bhe_n, 1);
        chk("R1", "a0",    a0, 1);
        chk("R1", "we",    bus_we, 0);
        chk("R1", "done",  done, 0);
        chk("R1", "rdata", rdata, 0);
        chk("R1", "addr",  bus_addr, 0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk);
        #1;
        // fill every row with aligned word writes (R2, R10)
        for (int i = 0; i < (1 << DL); i++)
            issue(1'b1, 1'b1, 20'(i * 2), 16'(i * 16'h0103) ^ 16'h5A3C);
        // aligned word reads, some at high addresses that alias (R2, R12)
        issue(1'b0, 1'b1, 20'h00000, 16'h0);
        issue(1'b0, 1'b1, 20'h0003E, 16'h0);
        issue(1'b0, 1'b1, 20'hA5432, 16'h0);
        // byte reads on both lanes (R3, R4)
        issue(1'b0, 1'b0, 20'h00010, 16'h0);
        issue(1'b0, 1'b0, 20'h00011, 16'h0);
        issue(1'b0, 1'b0, 20'h7FF81, 16'h0);
        // split word reads (R5) and the wrap corner (R6)
        issue(1'b0, 1'b1, 20'h00005, 16'h0);
        issue(1'b0, 1'b1, 20'h3C07F, 16'h0);
        issue(1'b0, 1'b1, 20'hFFFFF, 16'h0);
        // byte writes then word read of the same row (R7)
        issue(1'b1, 1'b0, 20'h00021, 16'hFFC6);
        issue(1'b0, 1'b1, 20'h00020, 16'h0);
        issue(1'b1, 1'b0, 20'h00040, 16'h7E91);
        issue(1'b0, 1'b1, 20'h00040, 16'h0);
        // split writes, including across the top of memory (R5, R6)
        issue(1'b1, 1'b1, 20'h0000B, 16'hBEEF);
        issue(1'b0, 1'b1, 20'h0000A, 16'h0);
        issue(1'b0, 1'b1, 20'h0000C, 16'h0);
        issue(1'b1, 1'b1, 20'hFFFFF, 16'hC0DE);
        issue(1'b0, 1'b1, 20'h00000, 16'h0);
        issue(1'b0, 1'b0, 20'h0007F, 16'h0);
        // stray request while busy must be ignored (R8)
        issue(1'b0, 1'b1, 20'h00031, 16'h0);
        req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1;
        req_addr = 20'h00032; req_wdata = 16'hDEAD;
        @(posedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        issue(1'b0, 1'b1, 20'h00032, 16'h0);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R8", "queue drained", 32'(q.size()), 0);
        summary();
    end

endmodule